// File: doc/BRIEF.md
# Masked fault latch and flag controller

This block sits between the analog fault comparators of a two-channel differential line driver and its register interface. It receives the raw per-channel conditions (short to supply, short to ground, current limit, excessive offset, open load) and the device-wide conditions (thermal warning, thermal shutdown, supply overvoltage). It qualifies each condition with the diagnostic enable and a per-bit mask, and holds the result in sticky fault registers that clear on read. From those registers it drives an active-low fault flag and a status byte.

Each channel runs a small state machine with three states. RUN is the normal driving state. TRIP means the output is off and at high impedance. OLT means the output is off while the open-load self-test runs. The transitions are as follows. RUN goes to TRIP on a qualified short or a device-wide trip. RUN goes to OLT on a 0-to-1 change of the test request while diagnostics are on. OLT goes to RUN when the test window expires. OLT goes to TRIP on a qualified short or trip. TRIP goes to RUN on that channel's retry pulse, but only once the trip cause is gone. The test window is counted in ticks of a one-per-microsecond enable, so its length is a parameter.

Top module: `fault_flag_ctrl`

## Requirements
- R1: After reset, all three fault registers read 0x00, `flag_n` is 1, `drv_hiz` is 00, both channels are on while the device is active, and `status` equals {5'b0, DEV_ID}.
- R2: A fault bit is latched only when `cfg_diag` is 1 and the mask bit at the same position is 1. Channel registers use bit 7 for short to supply, bit 6 for short to ground, bit 5 for current limit, bit 3 for offset and bit 2 for open load. Bits 4, 1 and 0 are always 0.
- R3: A qualified short (bit 7 or 6) turns that channel off and puts it in high impedance, and leaves the other channel running. The channel stays off until its retry pulse arrives. A retry pulse is ignored while the short is still present.
- R4: A qualified current limit sets bit 5 and leaves the channel driving.
- R5: The general register uses bit 6 for thermal warning, bit 5 for thermal shutdown and bit 4 for overvoltage. A qualified thermal shutdown or overvoltage turns both channels off into high impedance, and each channel returns only on its own retry pulse. A thermal warning only reports.
- R6: With `cfg_diag` set, a 0-to-1 change of `olt_req[ch]` switches that channel off (not high impedance) for OLT_US ticks of `us_tick`. The channel returns on the tick that completes the window. Open load (bit 2) is latched only inside the window. A request held at 1 starts no new test.
- R7: The offset bit (bit 3) is latched only while the outputs are muted. The outputs are muted when `mute_n` is low or `cfg_mute` is 1, and `muted` shows this state.
- R8: A read strobe clears its register on the next edge. A bit whose qualified condition is present in the read cycle stays set.
- R9: `flag_n` is 0 whenever any fault register bit is set. `status` bit 7 is the inverse of `flag_n`, bits 6 and 5 are the left and right high-impedance states, bits 4 and 3 copy the left and right offset bits, and bits 2..0 are DEV_ID.
- R10: When `shdn_n` is low or `cfg_enable` is 0, `drv_on` is 00 without high impedance. Latched faults are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| shdn_n | input | 1 | Shutdown pin, low forces off |
| mute_n | input | 1 | Mute pin, low forces mute |
| cfg_diag | input | 1 | Diagnostic enable |
| cfg_enable | input | 1 | Device enable from configuration |
| cfg_mute | input | 1 | Mute from configuration |
| olt_req | input | 2 | Open-load test request per channel (0 left, 1 right) |
| retry_pulse | input | 2 | Per-channel retry pulses |
| rd_chan | input | 2 | Read strobes of the left/right fault registers |
| rd_gen | input | 1 | Read strobe of the general fault register |
| chan_mask_l | input | 8 | Left channel mask |
| chan_mask_r | input | 8 | Right channel mask |
| gen_mask | input | 8 | General fault mask |
| raw_svdd | input | 2 | Raw short to supply per channel |
| raw_sgnd | input | 2 | Raw short to ground per channel |
| raw_limit | input | 2 | Raw current limit per channel |
| raw_offset | input | 2 | Raw excessive offset per channel |
| raw_open | input | 2 | Raw open-load result per channel |
| raw_twarn | input | 1 | Raw thermal warning |
| raw_tshdn | input | 1 | Raw thermal shutdown |
| raw_ovv | input | 1 | Raw supply overvoltage |
| fault_l | output | 8 | Left channel fault register |
| fault_r | output | 8 | Right channel fault register |
| fault_g | output | 8 | General fault register |
| status | output | 8 | Flag/status byte |
| flag_n | output | 1 | Fault flag, active low |
| drv_on | output | 2 | Channel driving per channel |
| drv_hiz | output | 2 | Channel in high impedance per channel |
| muted | output | 1 | Outputs muted |

## Verification
A channel state machine stuck in TRIP or OLT shows at `drv_on` and `drv_hiz` one edge after the event that should have moved it, so each transition is checked exactly one edge later. A wrong latch or clear shows in the fault byte and in `flag_n` and `status` on the same edge, because those are decoded combinationally from the registers. An off-by-one in the window counter shows as the channel returning one tick early or late, so the bench samples both the tick before the expected return and the tick of it.

// File: rtl/fflag_pkg.sv
package fflag_pkg;
    localparam int NCH    = 2;
    localparam int B_SVDD = 7;
    localparam int B_SGND = 6;
    localparam int B_LIM  = 5;
    localparam int B_OFF  = 3;
    localparam int B_OPEN = 2;
    localparam int B_TWRN = 6;
    localparam int B_TSHD = 5;
    localparam int B_OVV  = 4;

    typedef enum logic [1:0] {
        CH_RUN  = 2'd0,
        CH_TRIP = 2'd1,
        CH_OLT  = 2'd2
    } chan_st_e;
endpackage

// File: rtl/fflag_gen.sv
module fflag_gen
    import fflag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       diag,
    input  logic [7:0] mask,
    input  logic       rd,
    input  logic       raw_twarn,
    input  logic       raw_tshdn,
    input  logic       raw_ovv,
    output logic [7:0] fault,
    output logic       glob_trip
);
    logic q_twarn, q_tshdn, q_ovv;
    logic [7:0] set_v, fault_q;
    logic unused_gmask;

    assign unused_gmask = ^{mask[7], mask[3:0]};
    assign q_twarn = diag & mask[B_TWRN] & raw_twarn;
    assign q_tshdn = diag & mask[B_TSHD] & raw_tshdn;
    assign q_ovv   = diag & mask[B_OVV]  & raw_ovv;

    always_comb begin
        set_v = '0;
        set_v[B_TWRN] = q_twarn;
        set_v[B_TSHD] = q_tshdn;
        set_v[B_OVV]  = q_ovv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fault_q <= '0;
        else        fault_q <= (rd ? 8'h00 : fault_q) | set_v;
    end

    assign fault     = fault_q;
    assign glob_trip = q_tshdn | q_ovv;

    assert_keep_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && q_twarn) |=> fault[B_TWRN])
        else $error("general bit lost on read");
endmodule

// File: rtl/fflag_chan.sv
module fflag_chan
    import fflag_pkg::*;
#(
    parameter int OLT_US = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       us_tick,
    input  logic       diag,
    input  logic       muted,
    input  logic       dev_active,
    input  logic [7:0] mask,
    input  logic       rd,
    input  logic       retry,
    input  logic       old_bit,
    input  logic       glob_trip,
    input  logic       raw_svdd,
    input  logic       raw_sgnd,
    input  logic       raw_limit,
    input  logic       raw_offset,
    input  logic       raw_open,
    output logic [7:0] fault,
    output logic       ch_on,
    output logic       ch_hiz
);
    localparam int CW = $clog2(OLT_US + 1);
    localparam logic [CW-1:0] LAST = CW'(OLT_US - 1);

    chan_st_e st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic old_q;
    logic q_svdd, q_sgnd, q_lim, q_off, q_open;
    logic trip, start, done;
    logic [7:0] set_v, fault_q;
    logic unused_mask;

    assign unused_mask = ^{mask[4], mask[1:0]};

    assign q_svdd = diag & mask[B_SVDD] & raw_svdd;
    assign q_sgnd = diag & mask[B_SGND] & raw_sgnd;
    assign q_lim  = diag & mask[B_LIM]  & raw_limit;
    assign q_off  = diag & mask[B_OFF]  & raw_offset & muted;
    assign q_open = diag & mask[B_OPEN] & raw_open & (st_q == CH_OLT);

    assign trip  = q_svdd | q_sgnd | glob_trip;
    assign start = diag & old_bit & ~old_q;
    assign done  = us_tick && (cnt_q == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_RUN;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_RUN:  if (trip) st_d = CH_TRIP;
                     else if (start) st_d = CH_OLT;
            CH_TRIP: if (!trip && retry) st_d = CH_RUN;
            CH_OLT:  if (trip) st_d = CH_TRIP;
                     else if (done) st_d = CH_RUN;
            default: st_d = CH_RUN;
        endcase
    end

    // outputs
    always_comb begin
        ch_on  = (st_q == CH_RUN) && dev_active;
        ch_hiz = (st_q == CH_TRIP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            old_q <= 1'b0;
        end else begin
            old_q <= old_bit;
            if (st_q != CH_OLT || done) cnt_q <= '0;
            else if (us_tick)           cnt_q <= cnt_q + CW'(1);
        end
    end

    always_comb begin
        set_v = '0;
        set_v[B_SVDD] = q_svdd;
        set_v[B_SGND] = q_sgnd;
        set_v[B_LIM]  = q_lim;
        set_v[B_OFF]  = q_off;
        set_v[B_OPEN] = q_open;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fault_q <= '0;
        else        fault_q <= (rd ? 8'h00 : fault_q) | set_v;
    end

    assign fault = fault_q;

    assert_short_trips_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q_svdd || q_sgnd) |=> (!ch_on && ch_hiz))
        else $error("short did not trip channel");

    assert_test_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_RUN && start && !trip) |=> (!ch_on && !ch_hiz))
        else $error("open-load test did not switch off");

    assert_window_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(OLT_US))
        else $error("window counter overran");

    assert_keep_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && q_lim) |=> fault[B_LIM])
        else $error("limit bit lost on read");

    assert_offset_muted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!muted && !fault[B_OFF]) |=> !fault[B_OFF])
        else $error("offset latched while playing");
endmodule

// File: rtl/fault_flag_ctrl.sv
module fault_flag_ctrl
    import fflag_pkg::*;
#(
    parameter int         OLT_US = 1000,
    parameter logic [2:0] DEV_ID = 3'b100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       us_tick,
    input  logic       shdn_n,
    input  logic       mute_n,
    input  logic       cfg_diag,
    input  logic       cfg_enable,
    input  logic       cfg_mute,
    input  logic [1:0] olt_req,
    input  logic [1:0] retry_pulse,
    input  logic [1:0] rd_chan,
    input  logic       rd_gen,
    input  logic [7:0] chan_mask_l,
    input  logic [7:0] chan_mask_r,
    input  logic [7:0] gen_mask,
    input  logic [1:0] raw_svdd,
    input  logic [1:0] raw_sgnd,
    input  logic [1:0] raw_limit,
    input  logic [1:0] raw_offset,
    input  logic [1:0] raw_open,
    input  logic       raw_twarn,
    input  logic       raw_tshdn,
    input  logic       raw_ovv,
    output logic [7:0] fault_l,
    output logic [7:0] fault_r,
    output logic [7:0] fault_g,
    output logic [7:0] status,
    output logic       flag_n,
    output logic [1:0] drv_on,
    output logic [1:0] drv_hiz,
    output logic       muted
);
    logic dev_active, glob_trip, flag_low;
    logic [7:0] cmask [NCH];
    logic [7:0] cfault [NCH];

    assign dev_active = shdn_n & cfg_enable;
    assign muted      = ~mute_n | cfg_mute;
    assign cmask[0]   = chan_mask_l;
    assign cmask[1]   = chan_mask_r;

    fflag_gen u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .diag      (cfg_diag),
        .mask      (gen_mask),
        .rd        (rd_gen),
        .raw_twarn (raw_twarn),
        .raw_tshdn (raw_tshdn),
        .raw_ovv   (raw_ovv),
        .fault     (fault_g),
        .glob_trip (glob_trip)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        fflag_chan #(.OLT_US(OLT_US)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .us_tick    (us_tick),
            .diag       (cfg_diag),
            .muted      (muted),
            .dev_active (dev_active),
            .mask       (cmask[ch]),
            .rd         (rd_chan[ch]),
            .retry      (retry_pulse[ch]),
            .old_bit    (olt_req[ch]),
            .glob_trip  (glob_trip),
            .raw_svdd   (raw_svdd[ch]),
            .raw_sgnd   (raw_sgnd[ch]),
            .raw_limit  (raw_limit[ch]),
            .raw_offset (raw_offset[ch]),
            .raw_open   (raw_open[ch]),
            .fault      (cfault[ch]),
            .ch_on      (drv_on[ch]),
            .ch_hiz     (drv_hiz[ch])
        );
    end

    assign fault_l  = cfault[0];
    assign fault_r  = cfault[1];
    assign flag_low = (|fault_l) | (|fault_r) | (|fault_g);
    assign flag_n   = ~flag_low;
    assign status   = {flag_low, drv_hiz[0], drv_hiz[1],
                       fault_l[B_OFF], fault_r[B_OFF], DEV_ID};

    assert_global_trip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        glob_trip |=> (drv_on == 2'b00 && drv_hiz == 2'b11))
        else $error("global trip left a channel on");

    assert_flag_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|fault_g) |-> (!flag_n && status[7]))
        else $error("flag not asserted for general fault");
endmodule

// File: tb/fault_flag_ctrl_test.sv
module fault_flag_ctrl_test;
    localparam int OLT = 8;
    localparam logic [2:0] ID = 3'b100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic us_tick, shdn_n, mute_n, cfg_diag, cfg_enable, cfg_mute;
    logic [1:0] olt_req, retry_pulse, rd_chan;
    logic rd_gen;
    logic [7:0] chan_mask_l, chan_mask_r, gen_mask;
    logic [1:0] raw_svdd, raw_sgnd, raw_limit, raw_offset, raw_open;
    logic raw_twarn, raw_tshdn, raw_ovv;
    logic [7:0] fault_l, fault_r, fault_g, status;
    logic flag_n, muted;
    logic [1:0] drv_on, drv_hiz;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    fault_flag_ctrl #(.OLT_US(OLT), .DEV_ID(ID)) uut (.*);

    // diag, mask[8], raw{svdd,sgnd,limit,offset,open}, mute_n, exp fault[8], exp on
    localparam logic [23:0] VEC [9] = '{
        {1'b0, 8'hFF, 5'b10000, 1'b1, 8'h00, 1'b1},
        {1'b1, 8'h00, 5'b10000, 1'b1, 8'h00, 1'b1},
        {1'b1, 8'h80, 5'b10000, 1'b1, 8'h80, 1'b0},
        {1'b1, 8'h40, 5'b01000, 1'b1, 8'h40, 1'b0},
        {1'b1, 8'h20, 5'b00100, 1'b1, 8'h20, 1'b1},
        {1'b1, 8'h08, 5'b00010, 1'b1, 8'h00, 1'b1},
        {1'b1, 8'h08, 5'b00010, 1'b0, 8'h08, 1'b1},
        {1'b1, 8'hFF, 5'b00001, 1'b1, 8'h00, 1'b1},
        {1'b1, 8'h60, 5'b10100, 1'b1, 8'h20, 1'b1}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic defaults();
        us_tick = 0; shdn_n = 1; mute_n = 1; cfg_diag = 1; cfg_enable = 1; cfg_mute = 0;
        olt_req = 0; retry_pulse = 0; rd_chan = 0; rd_gen = 0;
        chan_mask_l = 8'hFF; chan_mask_r = 8'hFF; gen_mask = 8'h70;
        raw_svdd = 0; raw_sgnd = 0; raw_limit = 0; raw_offset = 0; raw_open = 0;
        raw_twarn = 0; raw_tshdn = 0; raw_ovv = 0;
    endtask

    task automatic do_reset();
        defaults();
        rst_n = 0;
        step();
        rst_n = 1;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [23:0] v;
        defaults();
        #5;
        do_reset();
        // R1 reset state
        chk("R1 fault_l", fault_l, 8'h00);
        chk("R1 fault_r", fault_r, 8'h00);
        chk("R1 fault_g", fault_g, 8'h00);
        chk("R1 flag_n", {7'b0, flag_n}, 8'h01);
        chk("R1 status", status, {5'b0, ID});
        chk("R1 drv_on/hiz", {4'b0, drv_on, drv_hiz}, 8'h0C);

        // table: R2 R3 R4 R6 R7 on the left channel
        for (int i = 0; i < 9; i++) begin
            do_reset();
            v = VEC[i];
            cfg_diag = v[23];
            chan_mask_l = v[22:15];
            {raw_svdd[0], raw_sgnd[0], raw_limit[0], raw_offset[0], raw_open[0]} = v[14:10];
            mute_n = v[9];
            step();
            chk($sformatf("R2/R3/R4/R6/R7 vector %0d fault", i), fault_l, v[8:1]);
            chk($sformatf("R2/R3/R4/R6/R7 vector %0d on", i), {7'b0, drv_on[0]}, {7'b0, v[0]});
        end

        // R3 trip, hold off, ignored retry, recovery
        do_reset();
        raw_svdd[0] = 1; step(); raw_svdd[0] = 0; step();
        chk("R3 stays off", {4'b0, drv_on, drv_hiz}, 8'h09);
        chk("R9 status on trip", status, {3'b110, 2'b00, ID});
        raw_svdd[0] = 1; retry_pulse[0] = 1; step();
        chk("R3 retry ignored", {7'b0, drv_on[0]}, 8'h00);
        raw_svdd[0] = 0; retry_pulse[0] = 0; step();
        retry_pulse[0] = 1; step(); retry_pulse[0] = 0;
        chk("R3 retry recovers", {4'b0, drv_on, drv_hiz}, 8'h0C);
        chk("R9 flag still low", {7'b0, flag_n}, 8'h00);
        // R8 clear on read and coincident raw
        rd_chan[0] = 1; step(); rd_chan[0] = 0;
        chk("R8 cleared", fault_l, 8'h00);
        chk("R9 flag released", {7'b0, flag_n}, 8'h01);
        raw_limit[0] = 1; step();
        rd_chan[0] = 1; step();
        chk("R8 kept on read", fault_l, 8'h20);
        raw_limit[0] = 0; step(); rd_chan[0] = 0;
        chk("R8 cleared after", fault_l, 8'h00);

        // R5 global faults
        do_reset();
        raw_tshdn = 1; step(); raw_tshdn = 0;
        chk("R5 tshdn bit", fault_g, 8'h20);
        chk("R5 both off", {4'b0, drv_on, drv_hiz}, 8'h03);
        retry_pulse[1] = 1; step(); retry_pulse[1] = 0;
        chk("R5 right retry only", {6'b0, drv_on}, 8'h02);
        retry_pulse[0] = 1; step(); retry_pulse[0] = 0;
        chk("R5 left retry", {6'b0, drv_on}, 8'h03);
        rd_gen = 1; step(); rd_gen = 0;
        chk("R5 read clears", fault_g, 8'h00);
        raw_twarn = 1; step(); raw_twarn = 0;
        chk("R5 twarn bit", fault_g, 8'h40);
        chk("R5 twarn keeps on", {6'b0, drv_on}, 8'h03);
        raw_ovv = 1; step(); raw_ovv = 0;
        chk("R5 ovv", {fault_g[7:4], drv_on, drv_hiz}, {4'b0101, 4'b0011});

        // R6 open-load window
        do_reset();
        olt_req[0] = 1; step();
        chk("R6 test off", {4'b0, drv_on, drv_hiz}, 8'h08);
        raw_open[0] = 1; step(); raw_open[0] = 0; step(); step();
        chk("R6 open latched", fault_l, 8'h04);
        chk("R6 no tick holds", {7'b0, drv_on[0]}, 8'h00);
        us_tick = 1;
        repeat (OLT - 1) step();
        chk("R6 tick before end", {7'b0, drv_on[0]}, 8'h00);
        step();
        chk("R6 window end", {7'b0, drv_on[0]}, 8'h01);
        step();
        chk("R6 held request no restart", {7'b0, drv_on[0]}, 8'h01);
        olt_req[0] = 0; step(); olt_req[0] = 1; step();
        chk("R6 retrigger", {7'b0, drv_on[0]}, 8'h00);
        repeat (OLT) step();
        us_tick = 0;
        chk("R6 second end", {7'b0, drv_on[0]}, 8'h01);

        // R9 right offset in status, R7 mute pin
        do_reset();
        mute_n = 0; chan_mask_r = 8'h08; raw_offset[1] = 1; step(); raw_offset[1] = 0;
        chk("R7 muted pin", {7'b0, muted}, 8'h01);
        chk("R9 status offset r", status, {1'b1, 2'b00, 1'b0, 1'b1, ID});
        mute_n = 1; cfg_mute = 1; #1;
        chk("R7 cfg mute", {7'b0, muted}, 8'h01);

        // R10 shutdown and enable override
        shdn_n = 0; #1;
        chk("R10 shdn off", {4'b0, drv_on, drv_hiz}, 8'h00);
        step();
        chk("R10 faults kept", fault_r, 8'h08);
        shdn_n = 1; cfg_enable = 0; #1;
        chk("R10 enable off", {6'b0, drv_on}, 8'h00);
        cfg_enable = 1; #1;
        chk("R10 back on", {6'b0, drv_on}, 8'h03);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule